// File: doc/BRIEF.md
# Serial Command Decoder and RAM Writer

This block sits at the front of a dot-matrix display controller. A host sends commands over a three-wire synchronous link: an active-low select, a shift clock and a data line. The block samples these three lines with the system clock. It puts the bits together into bytes and decodes the first byte of each command. Each command becomes either a single-cycle RAM write strobe or an update to a control register.

Two banks are supported. Each bank has three RAMs:
- a character-code RAM, 16 words of 8 bits;
- a pattern RAM, 16 words of 35 bits;
- a symbol RAM, 16 words of 1 bit.

The control registers are a 10-bit brightness value, a 4-bit digit count and a 2-bit all-lights mode.

The three write strobes share one bank bit, one address and one data bus. After an opcode, the data bytes of a RAM command keep streaming at addresses that increment automatically. The stream continues until select is released.

Top module: `serial_cmd_writer`

## Requirements
- R1: While `sel_n` is high, shift-clock edges are ignored. No strobe fires and no register changes.
- R2: A falling `sel_n` restarts bit counting. Any partial byte received before select was released is discarded. Bytes are framed in groups of 8 rising `sclk` edges, least significant bit first.
- R3: The first byte of a command is the opcode. Bits 7:4 are the command and bits 3:0 are an address or parameter. Bit 7 selects bank A (0) or B (1) for the RAM commands. Bits 6:4 select the RAM: 001 is character code, 010 is pattern, 011 is symbol.
- R4: After a character-code opcode, each byte is written whole (`code_we`, data on `wr_data[7:0]`) at the current address. The address then increments and wraps from 15 back to 0.
- R5: After a pattern opcode, five bytes form one 35-bit word. In byte k (k = 0 to 4), bit j (j = 0 to 6) goes to word bit k+5j, and bit 7 is ignored. `pat_we` fires only after the fifth byte, and the address then increments.
- R6: After a symbol opcode, bit 0 of each byte is written (`sym_we`, data on `wr_data[0]`) with auto-increment. All other bits are ignored.
- R7: Opcode 0101 sets brightness in two bytes. Bits 1:0 of the opcode byte become `bright[1:0]`, and the second byte becomes `bright[9:2]`. `bright` changes only when the second byte arrives.
- R8: Opcode 0110 is a single byte and loads `digits` from its bits 3:0.
- R9: Opcode 0111 is a single byte. `lamp[0]` takes bit 0 (all-off request) and `lamp[1]` takes bit 1 (all-on request).
- R10: Reset clears `bright`, `digits` (0 means 16 digits), `lamp`, the address and all strobes.
- R11: Data bytes stay bound to the most recent RAM opcode until `sel_n` rises. A rise of `sel_n` in the middle of a pattern drops the partial word. The next byte after select falls again is an opcode.
- R12: Opcodes 0000, 1000, 1101, 1110 and 1111 are ignored. They cause no strobe and no register change, and the next byte is taken as an opcode.
- R13: At most one write strobe is high in any cycle, and each write lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial shift clock, data taken on rising edge |
| sdat | input | 1 | Serial data, LSB first |
| code_we | output | 1 | Character-code RAM write strobe |
| pat_we | output | 1 | Pattern RAM write strobe |
| sym_we | output | 1 | Symbol RAM write strobe |
| wr_bank | output | 1 | Bank of the current write (0 = A, 1 = B) |
| wr_addr | output | 4 | Address of the current write |
| wr_data | output | 35 | Write data, right-aligned for narrow RAMs |
| bright | output | 10 | Brightness register |
| digits | output | 4 | Digit-count register |
| lamp | output | 2 | All-lights mode: bit 0 all-off, bit 1 all-on |

## Verification
The serial lines pass through two synchroniser stages. An edge detector and the decode register follow. A strobe or a register update therefore appears three system-clock edges after the rising `sclk` that completes a byte. A change on `sel_n` takes effect after two edges. The bench holds each `sclk` level for two clock periods. It records every strobe on the falling clock edge, so a one-cycle pulse is never missed. Register and mirror comparisons are made only after at least six idle cycles following the final bit, well beyond that three-edge delay.

// File: rtl/serial_cmd_writer.sv
module serial_cmd_writer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_n,
  input  logic        sclk,
  input  logic        sdat,
  output logic        code_we,
  output logic        pat_we,
  output logic        sym_we,
  output logic        wr_bank,
  output logic [3:0]  wr_addr,
  output logic [34:0] wr_data,
  output logic [9:0]  bright,
  output logic [3:0]  digits,
  output logic [1:0]  lamp
);
  localparam int PW = 35;
  localparam int COLS = 5;

  typedef enum logic [2:0] {M_OP, M_CODE, M_PAT, M_SYM, M_BRI} mode_t;

  logic [2:0]    ck_s;
  logic [1:0]    dt_s, cs_s;
  logic [6:0]    shreg;
  logic [2:0]    bitcnt, col;
  logic [3:0]    addr;
  logic          bank;
  logic [1:0]    bri_lo;
  logic [PW-1:0] acc, pat_mix;
  mode_t         mode;

  wire       desel     = cs_s[1];
  wire       rise      = ck_s[1] & ~ck_s[2];
  wire       bit_in    = dt_s[1];
  wire       byte_done = rise & ~desel & (bitcnt == 3'd7);
  wire [7:0] rx        = {bit_in, shreg};

  always_comb begin
    pat_mix = acc;
    for (int j = 0; j < 7; j++) begin
      int idx;
      idx = int'(col) + COLS * j;
      if (idx < PW) pat_mix[idx] = rx[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_s <= '0; dt_s <= '0; cs_s <= 2'b11;
    end else begin
      ck_s <= {ck_s[1:0], sclk};
      dt_s <= {dt_s[0], sdat};
      cs_s <= {cs_s[0], sel_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0; bitcnt <= '0; col <= '0; addr <= '0; bank <= 1'b0;
      bri_lo <= '0; acc <= '0; mode <= M_OP;
      code_we <= 1'b0; pat_we <= 1'b0; sym_we <= 1'b0;
      wr_bank <= 1'b0; wr_addr <= '0; wr_data <= '0;
      bright <= '0; digits <= '0; lamp <= '0;
    end else begin
      code_we <= 1'b0; pat_we <= 1'b0; sym_we <= 1'b0;
      if (desel) begin
        bitcnt <= '0; col <= '0; mode <= M_OP;
      end else if (rise) begin
        shreg  <= {bit_in, shreg[6:1]};
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          unique case (mode)
            M_OP: begin
              case (rx[6:4])
                3'b001: begin mode <= M_CODE; bank <= rx[7]; addr <= rx[3:0]; end
                3'b010: begin mode <= M_PAT; bank <= rx[7]; addr <= rx[3:0]; col <= '0; end
                3'b011: begin mode <= M_SYM; bank <= rx[7]; addr <= rx[3:0]; end
                3'b101: if (!rx[7]) begin mode <= M_BRI; bri_lo <= rx[1:0]; end
                3'b110: if (!rx[7]) digits <= rx[3:0];
                3'b111: if (!rx[7]) lamp <= rx[1:0];
                default: ;
              endcase
            end
            M_CODE: begin
              code_we <= 1'b1; wr_bank <= bank; wr_addr <= addr;
              wr_data <= {27'd0, rx}; addr <= addr + 4'd1;
            end
            M_SYM: begin
              sym_we <= 1'b1; wr_bank <= bank; wr_addr <= addr;
              wr_data <= {34'd0, rx[0]}; addr <= addr + 4'd1;
            end
            M_PAT: begin
              if (col == 3'(COLS - 1)) begin
                pat_we <= 1'b1; wr_bank <= bank; wr_addr <= addr;
                wr_data <= pat_mix; addr <= addr + 4'd1; col <= '0;
              end else begin
                acc <= pat_mix; col <= col + 3'd1;
              end
            end
            M_BRI: begin
              bright <= {rx, bri_lo}; mode <= M_OP;
            end
            default: mode <= M_OP;
          endcase
        end
      end
    end
  end

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !(code_we | pat_we | sym_we)); // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (code_we | pat_we | sym_we) |-> addr == wr_addr + 4'd1); // R4
  AST_PAT_LAST_COL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pat_we) |-> ($past(col) == 3'd4 && col == 3'd0)); // R5
  AST_BRIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_done && mode == M_BRI) |=> $stable(bright)); // R7
  AST_DIGITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(digits)); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({code_we, pat_we, sym_we})); // R13
endmodule

// File: tb/sim_serial_cmd_writer.sv
module sim_serial_cmd_writer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n, sel_n, sclk, sdat;
  logic code_we, pat_we, sym_we, wr_bank;
  logic [3:0] wr_addr, digits;
  logic [34:0] wr_data;
  logic [9:0] bright;
  logic [1:0] lamp;

  int total = 0, bad = 0, strobes = 0, multi = 0;
  logic [7:0]  code_m [2][16];
  logic [34:0] pat_m  [2][16];
  logic        sym_m  [2][16];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cmd_writer u0 (.clk, .rst_n, .sel_n, .sclk, .sdat, .code_we, .pat_we,
    .sym_we, .wr_bank, .wr_addr, .wr_data, .bright, .digits, .lamp);

  always @(negedge clk) begin
    if (int'(code_we) + int'(pat_we) + int'(sym_we) > 1) multi++;
    if (code_we) begin code_m[wr_bank][wr_addr] = wr_data[7:0]; strobes++; end
    if (pat_we)  begin pat_m[wr_bank][wr_addr]  = wr_data;      strobes++; end
    if (sym_we)  begin sym_m[wr_bank][wr_addr]  = wr_data[0];   strobes++; end
  end

  task automatic chk(input string req, input logic [34:0] act, input logic [34:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bits(input int n, input logic [7:0] v);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sdat = v[i]; sclk = 1'b0;
      repeat (2) @(negedge clk); sclk = 1'b1;
      repeat (2) @(negedge clk); sclk = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] v); send_bits(8, v); endtask
  task automatic open_f;  @(negedge clk); sel_n = 1'b0; repeat (4) @(negedge clk); endtask
  task automatic close_f; repeat (6) @(negedge clk); sel_n = 1'b1; repeat (4) @(negedge clk); endtask

  function automatic logic [7:0] code_val(input int b, input int a);
    return 8'((a * 37 + b * 101 + 5) & 255);
  endfunction
  function automatic logic [34:0] pat_val(input int b, input int a);
    logic [34:0] p;
    p = 35'h4D2C3B1A9 * 35'(a + 1);
    return b ? ~p : p;
  endfunction
  function automatic logic [7:0] col_byte(input logic [34:0] p, input int k);
    logic [7:0] r;
    r[7] = 1'b1;
    for (int j = 0; j < 7; j++) r[j] = p[k + 5 * j];
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int exp_str, sa;
    logic [9:0] prev_b;
    rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; sdat = 1'b0;
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 16; a++) begin code_m[b][a] = '0; pat_m[b][a] = '0; sym_m[b][a] = 1'b0; end
    repeat (5) @(negedge clk);
    // R10 reset state
    chk("R10 bright", 35'(bright), 35'd0);
    chk("R10 digits", 35'(digits), 35'd0);
    chk("R10 lamp", 35'(lamp), 35'd0);
    chk("R10 addr", 35'(wr_addr), 35'd0);
    chk("R10 strobes", 35'(strobes), 35'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R4 character-code sweep over both banks
    for (int b = 0; b < 2; b++) begin
      open_f; send(8'(8'h10 | (b << 7)));
      for (int a = 0; a < 16; a++) send(code_val(b, a));
      close_f;
    end
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 16; a++) chk("R3 R4 code", 35'(code_m[b][a]), 35'(code_val(b, a)));
    // R4 wrap 15 -> 0
    open_f; send(8'h1E); send(8'hA1); send(8'hA2); send(8'hA3); close_f;
    chk("R4 wrap e", 35'(code_m[0][14]), 35'h0A1);
    chk("R4 wrap f", 35'(code_m[0][15]), 35'h0A2);
    chk("R4 wrap 0", 35'(code_m[0][0]), 35'h0A3);
    exp_str = 35;

    // R5 pattern sweep
    for (int b = 0; b < 2; b++) begin
      open_f; send(8'(8'h20 | (b << 7)));
      for (int a = 0; a < 16; a++)
        for (int k = 0; k < 5; k++) send(col_byte(pat_val(b, a), k));
      close_f;
    end
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 16; a++) chk("R5 pattern", pat_m[b][a], pat_val(b, a));
    exp_str += 32;
    chk("R5 strobe count", 35'(strobes), 35'(exp_str));

    // R6 symbol sweep starting at address 3
    for (int b = 0; b < 2; b++) begin
      open_f; send(8'(8'h33 | (b << 7)));
      for (int i = 0; i < 16; i++) send(8'hFE | 8'(((i * 3 + b) >> 1) & 1));
      close_f;
    end
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 16; i++) begin
        sa = (i + 3) % 16;
        chk("R6 symbol", 35'(sym_m[b][sa]), 35'(((i * 3 + b) >> 1) & 1));
      end
    exp_str += 32;

    // R7 brightness, two-byte update
    for (int i = 0; i < 49; i++) begin
      logic [9:0] v;
      v = (i == 48) ? 10'h3FF : 10'((i * 87 + 5) % 1024);
      prev_b = bright;
      open_f; send({6'b010100, v[1:0]});
      repeat (6) @(negedge clk);
      chk("R7 hold after opcode", 35'(bright), 35'(prev_b));
      send(v[9:2]); close_f;
      chk("R7 bright", 35'(bright), 35'(v));
    end

    // R8 digit count
    for (int k = 0; k < 16; k++) begin
      open_f; send(8'(8'h60 | k)); close_f;
      chk("R8 digits", 35'(digits), 35'(k));
    end
    // R9 all-lights mode
    for (int m = 0; m < 4; m++) begin
      open_f; send(8'(8'h70 | m)); close_f;
      chk("R9 lamp", 35'(lamp), 35'(m));
    end

    // R12 undefined opcodes, then a real opcode in the same frame
    prev_b = bright;
    open_f; send(8'h00); send(8'h80); send(8'hD3); send(8'hE3); send(8'hF3); send(8'h65); close_f;
    chk("R12 no strobe", 35'(strobes), 35'(exp_str));
    chk("R12 bright", 35'(bright), 35'(prev_b));
    chk("R12 lamp", 35'(lamp), 35'd3);
    chk("R12 next opcode", 35'(digits), 35'd5);

    // R11 stream bound to opcode
    open_f; send(8'h12); send(8'h6C); close_f;
    exp_str += 1;
    chk("R11 bound code", 35'(code_m[0][2]), 35'h06C);
    chk("R11 bound digits", 35'(digits), 35'd5);
    // R11 partial pattern dropped
    open_f; send(8'h24); send(8'h11); send(8'h22); close_f;
    open_f; send(8'h6A); close_f;
    chk("R11 partial dropped", 35'(strobes), 35'(exp_str));
    chk("R11 opcode after reselect", 35'(digits), 35'd10);
    open_f; send(8'h24);
    for (int k = 0; k < 5; k++) send(col_byte(35'h123456789, k));
    close_f;
    exp_str += 1;
    chk("R11 column restart", pat_m[0][4], 35'h123456789);

    // R2 partial byte discarded across reselect
    open_f; send_bits(3, 8'hFF); close_f;
    open_f; send(8'h63); close_f;
    chk("R2 reframe", 35'(digits), 35'd3);
    // R1 clocks ignored while deselected
    send(8'h6F); send(8'h6F);
    repeat (6) @(negedge clk);
    chk("R1 deselected", 35'(digits), 35'd3);
    chk("R1 no strobe", 35'(strobes), 35'(exp_str));
    // R13
    chk("R13 one strobe", 35'(multi), 35'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule